// File: doc/BRIEF.md
# Tag-Sequential Set-Associative Lookup Controller

This block controls lookups in a set-associative cache whose data array is addressed only after the tag side has picked a way. A request gives a tag and a set index. The controller compares all ways of that set at once. It encodes the winning way as a binary number and then drives a single data-array address. That address carries the way number in its upper bits and the set index in its lower bits. A miss never reaches the data array. It is reported back to the requester, which then goes to the next level itself (look-aside).

The block also holds a small array of partial tags, one per way. In the first cycle after a request is accepted, this array either rejects the request outright or names a predicted way. For the predicted way, the data read is issued at once, without waiting for the full compare. In the second cycle the full tags confirm the guess, correct it with a re-issued read, or cancel it. Refills choose their victim with a round-robin pointer kept for each set.

Top module: `tsl_lookup`

## Requirements
- R1: After reset no way is valid, reqReady is 1, and respValid, dataAddrValid and dataKill are 0. Every lookup made before the first refill is a miss.
- R2: A request is accepted on a clock edge where reqValid and reqReady are both 1. Suppose no valid way in the set has a stored partial tag equal to the low 4 bits of the request tag. Then, in the cycle after acceptance, respValid=1 and respHit=0, with no data address issued.
- R3: If at least one valid way in the set has a matching partial tag, then in the cycle after acceptance dataAddrValid=1. In that cycle dataAddr = {predicted way, set}: bits [5:4] hold the lowest-numbered partial-matching way and bits [3:0] hold the set.
- R4: If the full tag matches in the predicted way, then in the second cycle after acceptance respValid=1, respHit=1, respMispredict=0 and dataKill=0, with no further data address.
- R5: If the full tag matches in a way other than the predicted one, then in the second cycle respHit=1, respMispredict=1, dataKill=1 and dataAddrValid=1. In that cycle dataAddr = {matching way, set}.
- R6: If a partial tag matches but no full tag matches, then in the second cycle respValid=1, respHit=0 and dataKill=1, with no data address. A partial-tag match alone never yields a hit.
- R7: A refill writes the full tag and its partial tag into the way named by the set's round-robin pointer. That pointer starts at way 0 and advances by one, modulo 4, for each refill of that set. A refilled tag is found by later lookups, and an overwritten tag misses.
- R8: reqReady is 0 while a lookup is in progress and while fillValid is 1. A refill takes priority over a request in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Lookup request |
| reqReady | output | 1 | Lookup can be accepted this cycle |
| reqTag | input | 8 | Request tag |
| reqSet | input | 4 | Request set index |
| fillValid | input | 1 | Refill write request |
| fillTag | input | 8 | Tag to install |
| fillSet | input | 4 | Set to refill |
| dataAddrValid | output | 1 | Data-array read strobe |
| dataAddr | output | 6 | Data-array address {way, set} |
| dataKill | output | 1 | Discard the speculative data read |
| respValid | output | 1 | Lookup completion strobe |
| respHit | output | 1 | Lookup hit (valid with respValid) |
| respMispredict | output | 1 | Prediction was wrong and a corrected read was issued |

## Verification
Each of the four lookup outcomes is driven on purpose: the partial-tag reject, the confirmed prediction, the corrected prediction, and the alias that matches on the low nibble but misses on the full tag. Tags that share a low nibble are placed in different ways to do this. Telling these cases apart shows that the predictor picks the lowest partial-matching way and that the full compare alone decides a hit. Five refills to one set show whether the victim pointer wraps. A stream of random refills and lookups, drawn from a tag pool that shares only two low nibbles, then tests how the predictor and the full compare interact across many fill orders.

// File: rtl/tsl_pkg.sv
package tsl_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_PRED, ST_CHECK} lookupState_e;

  typedef struct packed {
    logic latchReq;
    logic fillWrite;
    logic issuePred;
    logic issueFix;
  } strobes_t;
endpackage

// File: rtl/tsl_datapath.sv
module tsl_datapath
  import tsl_pkg::*;
#(
  parameter int SET_BITS = 4,
  parameter int WAYS     = 4,
  parameter int TAG_W    = 8,
  parameter int PTAG_W   = 4
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  strobes_t                         ctl,
  input  logic [TAG_W-1:0]                 reqTag,
  input  logic [SET_BITS-1:0]              reqSet,
  input  logic [TAG_W-1:0]                 fillTag,
  input  logic [SET_BITS-1:0]              fillSet,
  output logic                             partHit,
  output logic                             fullHit,
  output logic                             wayAgree,
  output logic [$clog2(WAYS)+SET_BITS-1:0] dataAddr
);
  localparam int SETS     = 1 << SET_BITS;
  localparam int WAY_BITS = $clog2(WAYS);

  logic [TAG_W-1:0]    tagMem  [SETS][WAYS];
  logic [PTAG_W-1:0]   ptagMem [SETS][WAYS];
  logic [WAYS-1:0]     validMem[SETS];
  logic [WAY_BITS-1:0] rrPtr   [SETS];

  logic [TAG_W-1:0]    reqTagQ;
  logic [SET_BITS-1:0] reqSetQ;
  logic [WAY_BITS-1:0] predWay, predWayQ, hitWay;
  logic [WAYS-1:0]     pMatch, fMatch;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqTagQ  <= '0;
      reqSetQ  <= '0;
      predWayQ <= '0;
    end else begin
      if (ctl.latchReq) begin
        reqTagQ <= reqTag;
        reqSetQ <= reqSet;
      end
      if (ctl.issuePred) predWayQ <= predWay;
    end
  end

  for (genvar s = 0; s < SETS; s++) begin : g_set
    always_ff @(posedge clk) begin
      if (!rstN) begin
        validMem[s] <= '0;
        rrPtr[s]    <= '0;
        for (int w = 0; w < WAYS; w++) begin
          tagMem[s][w]  <= '0;
          ptagMem[s][w] <= '0;
        end
      end else if (ctl.fillWrite && fillSet == SET_BITS'(s)) begin
        tagMem[s][rrPtr[s]]   <= fillTag;
        ptagMem[s][rrPtr[s]]  <= fillTag[PTAG_W-1:0];
        validMem[s][rrPtr[s]] <= 1'b1;
        rrPtr[s]              <= rrPtr[s] + 1'b1;
      end
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign pMatch[w] = validMem[reqSetQ][w] && ptagMem[reqSetQ][w] == reqTagQ[PTAG_W-1:0];
    assign fMatch[w] = validMem[reqSetQ][w] && tagMem[reqSetQ][w] == reqTagQ;
  end

  always_comb begin
    partHit = 1'b0;
    predWay = '0;
    fullHit = 1'b0;
    hitWay  = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (pMatch[w]) begin
        partHit = 1'b1;
        predWay = WAY_BITS'(w);
      end
      if (fMatch[w]) begin
        fullHit = 1'b1;
        hitWay  = WAY_BITS'(w);
      end
    end
  end

  assign wayAgree = (hitWay == predWayQ);
  assign dataAddr = {ctl.issueFix ? hitWay : predWay, reqSetQ};
endmodule

// File: rtl/tsl_control.sv
module tsl_control
  import tsl_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     fillValid,
  input  logic     partHit,
  input  logic     fullHit,
  input  logic     wayAgree,
  output strobes_t ctl,
  output logic     reqReady,
  output logic     dataAddrValid,
  output logic     dataKill,
  output logic     respValid,
  output logic     respHit,
  output logic     respMispredict
);
  lookupState_e state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    ctl            = '0;
    stateNext      = state;
    reqReady       = 1'b0;
    dataAddrValid  = 1'b0;
    dataKill       = 1'b0;
    respValid      = 1'b0;
    respHit        = 1'b0;
    respMispredict = 1'b0;
    unique case (state)
      ST_IDLE: begin
        reqReady = !fillValid;
        if (fillValid) begin
          ctl.fillWrite = 1'b1;
        end else if (reqValid) begin
          ctl.latchReq = 1'b1;
          stateNext    = ST_PRED;
        end
      end
      ST_PRED: begin
        if (!partHit) begin
          respValid = 1'b1;
          stateNext = ST_IDLE;
        end else begin
          ctl.issuePred = 1'b1;
          dataAddrValid = 1'b1;
          stateNext     = ST_CHECK;
        end
      end
      ST_CHECK: begin
        respValid = 1'b1;
        respHit   = fullHit;
        stateNext = ST_IDLE;
        if (fullHit && !wayAgree) begin
          ctl.issueFix   = 1'b1;
          dataAddrValid  = 1'b1;
          dataKill       = 1'b1;
          respMispredict = 1'b1;
        end else if (!fullHit) begin
          dataKill = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/tsl_lookup.sv
module tsl_lookup
  import tsl_pkg::*;
#(
  parameter int SET_BITS = 4,
  parameter int WAYS     = 4,
  parameter int TAG_W    = 8,
  parameter int PTAG_W   = 4
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             reqValid,
  output logic                             reqReady,
  input  logic [TAG_W-1:0]                 reqTag,
  input  logic [SET_BITS-1:0]              reqSet,
  input  logic                             fillValid,
  input  logic [TAG_W-1:0]                 fillTag,
  input  logic [SET_BITS-1:0]              fillSet,
  output logic                             dataAddrValid,
  output logic [$clog2(WAYS)+SET_BITS-1:0] dataAddr,
  output logic                             dataKill,
  output logic                             respValid,
  output logic                             respHit,
  output logic                             respMispredict
);
  strobes_t ctl;
  logic partHit, fullHit, wayAgree;

  tsl_control ctrl_i (
    .clk, .rstN, .reqValid, .fillValid, .partHit, .fullHit, .wayAgree,
    .ctl, .reqReady, .dataAddrValid, .dataKill, .respValid, .respHit,
    .respMispredict
  );

  tsl_datapath #(
    .SET_BITS(SET_BITS), .WAYS(WAYS), .TAG_W(TAG_W), .PTAG_W(PTAG_W)
  ) dp_i (
    .clk, .rstN, .ctl, .reqTag, .reqSet, .fillTag, .fillSet,
    .partHit, .fullHit, .wayAgree, .dataAddr
  );
endmodule

// File: rtl/tsl_lookup_chk.sv
module tsl_lookup_chk #(
  parameter int SET_BITS = 4,
  parameter int ADDR_W   = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              fillValid,
  input logic              dataAddrValid,
  input logic [ADDR_W-1:0] dataAddr,
  input logic              dataKill,
  input logic              respValid,
  input logic              respHit,
  input logic              respMispredict
);
  AST_HIT_NEEDS_RESP: assert property (@(posedge clk) disable iff (!rstN)
    respHit |-> respValid); // R4
  AST_MISS_NO_READ: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !respHit) |-> !dataAddrValid); // R6
  AST_MISPRED_FIX: assert property (@(posedge clk) disable iff (!rstN)
    respMispredict |-> (dataAddrValid && dataKill && respHit)); // R5
  AST_KILL_AFTER_ISSUE: assert property (@(posedge clk) disable iff (!rstN)
    dataKill |-> $past(dataAddrValid)); // R6
  AST_FIX_SAME_SET: assert property (@(posedge clk) disable iff (!rstN)
    (dataAddrValid && dataKill) |-> dataAddr[SET_BITS-1:0] == $past(dataAddr[SET_BITS-1:0])); // R5
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady); // R8
  AST_FILL_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    fillValid |-> !reqReady); // R8
endmodule

bind tsl_lookup tsl_lookup_chk #(.SET_BITS(SET_BITS), .ADDR_W($clog2(WAYS) + SET_BITS)) chk_i (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .fillValid(fillValid), .dataAddrValid(dataAddrValid), .dataAddr(dataAddr),
  .dataKill(dataKill), .respValid(respValid), .respHit(respHit),
  .respMispredict(respMispredict)
);

// File: tb/tsl_lookup_tb.sv
module tsl_lookup_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0, fillValid = 1'b0;
  logic       reqReady;
  logic [7:0] reqTag = '0, fillTag = '0;
  logic [3:0] reqSet = '0, fillSet = '0;
  logic       dataAddrValid, dataKill, respValid, respHit, respMispredict;
  logic [5:0] dataAddr;

  int checks = 0;
  int errors = 0;

  logic [7:0] mTag[16][4];
  logic       mVal[16][4];
  int         mRr[16];

  always #(CLK_PERIOD / 2) clk = ~clk;

  tsl_lookup dut_i (
    .clk, .rstN, .reqValid, .reqReady, .reqTag, .reqSet, .fillValid, .fillTag,
    .fillSet, .dataAddrValid, .dataAddr, .dataKill, .respValid, .respHit,
    .respMispredict
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doFill(input logic [7:0] tag, input logic [3:0] set);
    @(negedge clk);
    fillValid = 1'b1; fillTag = tag; fillSet = set; reqValid = 1'b1;
    #1 chk(reqReady == 1'b0, "R8 fill blocks request", reqReady, 0);
    @(negedge clk);
    fillValid = 1'b0; reqValid = 1'b0;
    mTag[set][mRr[set]] = tag;
    mVal[set][mRr[set]] = 1'b1;
    mRr[set] = (mRr[set] + 1) % 4;
  endtask

  task automatic doLookup(input logic [7:0] tag, input logic [3:0] set, input string req);
    int pw, fw;
    pw = -1; fw = -1;
    for (int w = 3; w >= 0; w--) begin
      if (mVal[set][w] && mTag[set][w][3:0] == tag[3:0]) pw = w;
      if (mVal[set][w] && mTag[set][w] == tag) fw = w;
    end
    @(negedge clk);
    chk(reqReady == 1'b1, {req, " ready when idle"}, reqReady, 1);
    reqValid = 1'b1; reqTag = tag; reqSet = set;
    @(negedge clk);
    reqValid = 1'b0;
    chk(reqReady == 1'b0, "R8 busy during lookup", reqReady, 0);
    if (pw < 0) begin
      chk(respValid && !respHit && !dataAddrValid, {req, " R2 partial reject"},
          {respValid, respHit, dataAddrValid}, 3'b100);
    end else begin
      chk(dataAddrValid && !respValid && dataAddr == {2'(pw), set}, {req, " R3 predicted read"},
          {dataAddrValid, respValid, dataAddr}, {1'b1, 1'b0, 2'(pw), set});
      @(negedge clk);
      if (fw == pw)
        chk(respValid && respHit && !respMispredict && !dataKill && !dataAddrValid, {req, " R4 confirmed"},
            {respValid, respHit, respMispredict, dataKill, dataAddrValid}, 5'b11000);
      else if (fw >= 0)
        chk(respValid && respHit && respMispredict && dataKill && dataAddrValid && dataAddr == {2'(fw), set},
            {req, " R5 corrected"}, {respHit, respMispredict, dataKill, dataAddrValid, dataAddr},
            {4'b1111, 2'(fw), set});
      else
        chk(respValid && !respHit && dataKill && !dataAddrValid && !respMispredict, {req, " R6 alias miss"},
            {respValid, respHit, dataKill, dataAddrValid}, 4'b1010);
    end
  endtask

  task automatic testReset();
    chk(reqReady && !respValid && !dataAddrValid && !dataKill, "R1 reset outputs",
        {reqReady, respValid, dataAddrValid, dataKill}, 4'b1000);
    doLookup(8'h00, 4'h0, "R1 empty lookup");
    doLookup(8'h5A, 4'hF, "R1 empty lookup");
  endtask

  task automatic testPredict();
    doFill(8'h15, 4'h2);
    doFill(8'h25, 4'h2);
    doFill(8'h37, 4'h2);
    doLookup(8'h15, 4'h2, "R4 way0");
    doLookup(8'h37, 4'h2, "R4 way2");
    doLookup(8'h25, 4'h2, "R5 way1 behind way0");
    doLookup(8'h45, 4'h2, "R6 alias");
    doLookup(8'h19, 4'h2, "R2 nibble reject");
  endtask

  task automatic testRoundRobin();
    doFill(8'hA1, 4'h7);
    doFill(8'hA2, 4'h7);
    doFill(8'hA3, 4'h7);
    doFill(8'hA4, 4'h7);
    doLookup(8'hA4, 4'h7, "R7 fourth fill in way3");
    doFill(8'hB5, 4'h7);
    doLookup(8'hA1, 4'h7, "R7 overwritten way0");
    doLookup(8'hB5, 4'h7, "R7 wrap to way0");
    doLookup(8'hA2, 4'h7, "R7 way1 kept");
  endtask

  task automatic testRandom();
    for (int i = 0; i < 400; i++) begin
      logic [7:0] t;
      logic [3:0] s;
      bit present;
      t = {4'($urandom_range(0, 15)), ($urandom_range(0, 1) != 0) ? 4'h5 : 4'hA};
      s = 4'($urandom_range(0, 3));
      present = 1'b0;
      for (int w = 0; w < 4; w++) if (mVal[s][w] && mTag[s][w] == t) present = 1'b1;
      if (!present && $urandom_range(0, 2) == 0) doFill(t, s);
      else doLookup(t, s, "R3 random stream");
    end
  endtask

  initial begin
    for (int s = 0; s < 16; s++) begin
      mRr[s] = 0;
      for (int w = 0; w < 4; w++) begin
        mVal[s][w] = 1'b0;
        mTag[s][w] = '0;
      end
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    testReset();
    testPredict();
    testRoundRobin();
    testRandom();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule